// File: doc/BRIEF.md
# I2C Bus Condition and Acknowledge Flag Monitor

This block listens to the clock and data lines of an I2C bus without ever driving them. Both lines are brought into the system clock domain through a two-stage synchroniser. On the synchronised samples the block finds clock rising edges, start conditions and stop conditions. It keeps three sticky flags that a controller can read: an acknowledge was seen, a start was seen (the address byte is under way), and a stop was seen (the master has finished and the bus is free).

Each flag has its own rule for being cleared, and those rules follow bus timing. A bit counter runs inside each byte and tells the flag logic which clock is the ninth of a byte and which is the first of the next one. A one-cycle release strobe lets the controller leave a transfer. The stop flag ignores this strobe. An enable input switches the whole monitor off and holds it cleared.

Top module: `i2c_bus_flag_mon`

## Requirements
- R1: A start condition is the synchronised SDA going from 1 to 0 while the synchronised SCL is 1 in both this sample and the one before. It sets `start_seen` and returns `bit_cnt` to 0.
- R2: A stop condition is the synchronised SDA going from 0 to 1 while SCL is 1 in both samples. It sets `stop_seen` and, in the same cycle, clears `ack_seen` and `start_seen`.
- R3: While enabled, each synchronised SCL rising edge moves `bit_cnt` from 0 to 1, or up by one, or from 9 back to 1. A stop condition leaves `bit_cnt` unchanged.
- R4: An SCL rising edge that takes `bit_cnt` from 8 to 9 sets `ack_seen` when SDA is 0 at that edge. It leaves `ack_seen` as it was when SDA is 1.
- R5: The SCL rising edge that takes `bit_cnt` from 9 to 1 (the first clock of the next byte) clears `ack_seen` and `start_seen`.
- R6: A `release_pulse` cycle clears `ack_seen` and `start_seen`. It has no effect on `stop_seen` or `bit_cnt`.
- R7: `stop_seen` clears only at the SCL rising edge that takes `bit_cnt` from 0 to 1, and only if a start condition was detected after the flag was last set. Rising edges with no such start between them and the setting do not clear it.
- R8: While `mon_en` is 0, all three flags and `bit_cnt` are 0 and bus events are ignored. After `mon_en` returns to 1, monitoring starts again from that cleared state.
- R9: Priority within one cycle is disable first, then clear events, then set events. A release in the same cycle as a start detection leaves `start_seen` at 0. A stop detection always sets `stop_seen`.
- R10: After reset all three flags and `bit_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| mon_en | input | 1 | Monitor enable; 0 holds everything cleared |
| release_pulse | input | 1 | One-cycle request to leave the current transfer |
| ack_seen | output | 1 | Acknowledge detected flag |
| start_seen | output | 1 | Start detected flag (address phase in progress) |
| stop_seen | output | 1 | Stop detected flag (bus released) |
| bit_cnt | output | 4 | Bit clock index within the current byte, 0 to 9 |

## Verification
The bench drives a release strobe in exactly the cycle the synchronised start edge appears. A design that lets a set win over a clear would show `start_seen` at 1 there. A full first byte ends with an acknowledge, and the first clock of the second byte must then clear both flags. A counter that wraps to 0 instead of 1, or that compares against the wrong edge index, would leave the flags set or clear them one clock early. The stop flag is checked in three cases: across clock edges that come with no new start, across release strobes, and at the first address clock after a repeated start. A design that clears it on any first clock, or when the release strobe arrives, is caught at once. Random bus traffic with enable drops mid-byte tests that a disabled monitor ignores bus events, and that it starts again cleanly from zero.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  // bit clocks per byte including the acknowledge slot
  localparam int BYTE_BITS = 9;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef struct packed {
    logic ack;
    logic start;
    logic stop;
  } flag_set_t;
endpackage

// File: rtl/i2cm_rst_sync.sv
module i2cm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines_in,
  output logic [WIDTH-1:0] lines_out
);
  // idle bus lines are high, so the chain resets to ones
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_comb stage_d[gi] = lines_in;
      end else begin : g_next
        always_comb stage_d[gi] = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '1;
        else        stage_q[gi] <= stage_d[gi];
      end
    end
  endgenerate

  assign lines_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2cm_cond_detect.sv
module i2cm_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_prev_q;
    start_det = scl_s & scl_prev_q &  sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q &  sda_s;
  end

  // start and stop are mutually exclusive and never coincide with a clock edge
  assert_cond_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({scl_rise, start_det, stop_det}) <= 1);
endmodule

// File: rtl/i2cm_bit_counter.sv
module i2cm_bit_counter
  import i2c_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_rise,
  input  logic             start_det,
  output logic [CNT_W-1:0] cnt,
  output logic             ninth_edge,
  output logic             wrap_edge,
  output logic             first_addr_edge
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] PENU = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ld;

  always_comb begin
    ninth_edge      = scl_rise & (cnt_q == PENU);
    wrap_edge       = scl_rise & (cnt_q == LAST);
    first_addr_edge = scl_rise & (cnt_q == '0);
  end

  always_comb begin
    cnt_ld = 1'b1;
    cnt_d  = cnt_q;
    if (!en)            cnt_d = '0;
    else if (start_det) cnt_d = '0;
    else if (scl_rise)  cnt_d = (cnt_q == LAST) ? ONE : cnt_q + ONE;
    else                cnt_ld = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_start_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en && start_det |=> cnt_q == '0);
  assert_wrap_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && scl_rise && cnt_q == LAST |=> cnt_q == ONE);
endmodule

// File: rtl/i2cm_flag_regs.sv
module i2cm_flag_regs
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      rel,
  input  logic      sda_s,
  input  logic      start_det,
  input  logic      stop_det,
  input  logic      ninth_edge,
  input  logic      wrap_edge,
  input  logic      first_addr_edge,
  output flag_set_t flags
);
  flag_set_t fl_q, fl_d;
  logic      arm_q, arm_d;
  logic      ack_sta_clr, stop_clr;

  always_comb begin
    ack_sta_clr = stop_det | wrap_edge | rel;
    stop_clr    = arm_q & first_addr_edge;
    fl_d  = fl_q;
    arm_d = arm_q;
    if (!en) begin
      fl_d  = '0;
      arm_d = 1'b0;
    end else begin
      // clear outranks set for acknowledge and start
      if (ack_sta_clr)               fl_d.ack = 1'b0;
      else if (ninth_edge && !sda_s) fl_d.ack = 1'b1;
      if (ack_sta_clr)               fl_d.start = 1'b0;
      else if (start_det)            fl_d.start = 1'b1;
      // stop detection always sets its own flag
      if (stop_det)                  fl_d.stop = 1'b1;
      else if (stop_clr)             fl_d.stop = 1'b0;
      if (stop_det || stop_clr)      arm_d = 1'b0;
      else if (start_det && fl_q.stop) arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      arm_q <= 1'b0;
    end else begin
      fl_q  <= fl_d;
      arm_q <= arm_d;
    end
  end

  assign flags = fl_q;

  assert_stop_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && stop_det |=> fl_q.stop && !fl_q.ack && !fl_q.start);
  assert_ack_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && ninth_edge && !sda_s && !rel |=> fl_q.ack);
  assert_wrap_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && wrap_edge |=> !fl_q.ack && !fl_q.start);
  assert_release_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && rel |=> !fl_q.ack && !fl_q.start);
  assert_release_keeps_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && rel && !stop_det && !first_addr_edge |=> $stable(fl_q.stop));
  assert_stop_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && arm_q && first_addr_edge |=> !fl_q.stop);
  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> fl_q == '0);
  assert_arm_needs_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> fl_q.stop);
endmodule

// File: rtl/i2c_bus_flag_mon.sv
module i2c_bus_flag_mon
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             mon_en,
  input  logic             release_pulse,
  output logic             ack_seen,
  output logic             start_seen,
  output logic             stop_seen,
  output logic [CNT_W-1:0] bit_cnt
);
  logic       rst_n_int;
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, start_det, stop_det;
  logic       ninth_edge, wrap_edge, first_addr_edge;
  flag_set_t  flags;

  i2cm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  i2cm_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .lines_in({scl_in, sda_in}),
    .lines_out(lines_s));

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cm_cond_detect u_det (
    .clk(clk), .rst_n(rst_n_int), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .start_det(start_det), .stop_det(stop_det));

  i2cm_bit_counter u_cnt (
    .clk(clk), .rst_n(rst_n_int), .en(mon_en), .scl_rise(scl_rise),
    .start_det(start_det), .cnt(bit_cnt), .ninth_edge(ninth_edge),
    .wrap_edge(wrap_edge), .first_addr_edge(first_addr_edge));

  i2cm_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n_int), .en(mon_en), .rel(release_pulse),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .ninth_edge(ninth_edge), .wrap_edge(wrap_edge),
    .first_addr_edge(first_addr_edge), .flags(flags));

  assign ack_seen   = flags.ack;
  assign start_seen = flags.start;
  assign stop_seen  = flags.stop;

  assert_reset_state_R10: assert property (@(posedge clk)
    !rst_n_int |=> !ack_seen && !start_seen && !stop_seen && bit_cnt == '0);
endmodule

// File: tb/i2c_bus_flag_mon_test.sv
module i2c_bus_flag_mon_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1, en = 1'b0, rel = 1'b0;
  logic ack_o, sta_o, sto_o;
  logic [3:0] cnt_o;

  int total = 0, bad = 0;
  int cycles = 0;

  // model state
  logic m_ack = 0, m_sta = 0, m_sto = 0, m_arm = 0, m_en = 0;
  logic [3:0] m_cnt = 0;
  logic pscl = 1, psda = 1;
  string m_tag = "R10";

  always #2.5 clk = ~clk;

  i2c_bus_flag_mon uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_drv),
    .mon_en(en), .release_pulse(rel), .ack_seen(ack_o),
    .start_seen(sta_o), .stop_seen(sto_o), .bit_cnt(cnt_o));

  function automatic logic [3:0] next_cnt(logic [3:0] c, logic sta, logic rise);
    if (sta)       return 4'd0;
    if (!rise)     return c;
    if (c == 4'd9) return 4'd1;
    return c + 4'd1;
  endfunction

  task automatic final_report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      final_report();
    end
  end

  task automatic compare();
    total++;
    if ({ack_o, sta_o, sto_o, cnt_o} !== {m_ack, m_sta, m_sto, m_cnt}) begin
      bad++;
      $display("FAIL %s: actual ack=%b start=%b stop=%b cnt=%0d expected ack=%b start=%b stop=%b cnt=%0d",
               m_tag, ack_o, sta_o, sto_o, cnt_o, m_ack, m_sta, m_sto, m_cnt);
    end
  endtask

  task automatic model(input logic ns, input logic nd, input logic r);
    logic rise, sta, sto, ninth, wrap, first, clr, sclr;
    rise = !pscl && ns;
    sta  = pscl && ns && psda && !nd;
    sto  = pscl && ns && !psda && nd;
    pscl = ns;
    psda = nd;
    if (!m_en) begin
      m_ack = 0; m_sta = 0; m_sto = 0; m_arm = 0; m_cnt = 0;
      m_tag = "R8";
      return;
    end
    ninth = rise && m_cnt == 4'd8;
    wrap  = rise && m_cnt == 4'd9;
    first = rise && m_cnt == 4'd0;
    clr   = sto || wrap || r;
    sclr  = m_arm && first;
    m_tag = "R3";
    if (ninth) m_tag = "R4";
    if (wrap)  m_tag = "R5";
    if (sta)   m_tag = "R1";
    if (sto)   m_tag = "R2";
    if (r)     m_tag = "R6";
    if (sclr)  m_tag = "R7";
    if (r && sta) m_tag = "R9";
    if (clr) m_ack = 0; else if (ninth && !nd) m_ack = 1;
    if (clr) m_sta = 0; else if (sta) m_sta = 1;
    if (sto || sclr) m_arm = 0; else if (sta && m_sto) m_arm = 1;
    if (sto) m_sto = 1; else if (sclr) m_sto = 0;
    m_cnt = next_cnt(m_cnt, sta, rise);
  endtask

  // bus change lands on the design two edges later; the release strobe is
  // placed in exactly the cycle the synchronised change is evaluated
  task automatic step(input logic ns, input logic nd, input logic r);
    @(negedge clk); scl_drv = ns; sda_drv = nd;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rel = r;
    @(negedge clk); rel = 1'b0;
    @(negedge clk); @(negedge clk);
    model(ns, nd, r);
    compare();
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); en = v;
    repeat (4) @(negedge clk);
    m_en = v;
    if (!v) begin m_ack = 0; m_sta = 0; m_sto = 0; m_arm = 0; m_cnt = 0; end
    m_tag = "R8";
    compare();
  endtask

  task automatic clock_bit(input logic b);
    step(1'b0, b, 1'b0);
    step(1'b1, b, 1'b0);
  endtask

  task automatic send_byte(input logic [8:0] bits);
    for (int i = 8; i >= 0; i--) clock_bit(bits[i]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    m_tag = "R10";
    compare();

    set_en(1'b1);
    // start, address byte with acknowledge low
    step(1'b1, 1'b0, 1'b0);                 // R1
    send_byte(9'b1010_0110_0);              // R4: ack set at 9th
    // second byte: first clock clears ack and start (R5), no ack at 9th
    send_byte(9'b0101_1001_1);
    // stop
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);                 // R2
    // clocks without a new start must not clear stop flag (R7)
    clock_bit(1'b1);
    step(1'b1, 1'b1, 1'b1);                 // release keeps stop (R6)
    // repeated start then first address clock clears stop (R7)
    step(1'b1, 1'b0, 1'b0);
    clock_bit(1'b0);
    send_byte(9'b0000_0001_0);
    step(1'b1, 1'b0, 1'b1);                 // release clears ack/start (R6)
    // stop, then release coincident with start (R9)
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    clock_bit(1'b1);                        // stop still cleared via armed start
    // disable mid byte, bus activity ignored (R8)
    clock_bit(1'b0);
    set_en(1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    clock_bit(1'b1);
    set_en(1'b1);

    // constrained random traffic
    for (int k = 0; k < 1500; k++) begin
      logic ns, nd, r;
      int pick;
      ns = pscl; nd = psda;
      pick = $urandom_range(0, 99);
      if (pick < 55) ns = ~pscl;
      else if (!pscl || pick < 70) nd = ~psda;
      r = ($urandom_range(0, 15) == 0);
      step(ns, nd, r);
      if ($urandom_range(0, 149) == 0) begin
        set_en(1'b0);
        set_en(1'b1);
      end
    end
    final_report();
  end
endmodule